// File: doc/BRIEF.md
# Lane Override Sequencer

This block reprograms the receive and transmit override registers of one serial PHY lane before and after a link reset. It does not touch the PHY directly. It issues single register reads and writes to an indirect register access engine. Each change is a read-modify-write chain built from a shadow copy of the last word read or written.

Two operations exist. The clear operation removes the receive override. The force operation works in four steps:
- it waits, within a bounded number of reads, for the lane to leave half-rate;
- it forces the receive DPLL mode and pulses the DPLL reset;
- it waits for a programmable settle time;
- unless the attenuation value asks for a skip, it forces the transmit attenuation.

A one-cycle completion pulse ends either operation. The selected lane moves every register address by a fixed stride.

Top module: `lane_ovr_seq`

## Requirements
- R1: While reset is held, and after it is released with no start, `busy`, `done` and `cmd_valid` are low.
- R2: A command for lane L uses address base + L*0x100. The bases are 0x2002 for RX status, 0x2001 for TX status, 0x2005 for RX override and 0x2004 for TX override.
- R3: The clear operation (`start_clear`) reads RX status. It then writes RX override with that value and bit 14 forced to 0. No other command is issued.
- R4: While `cmd_valid` is high and `cmd_done` is low, `cmd_write`, `cmd_addr` and `cmd_wdata` hold steady. The next command is presented only after `cmd_done`.
- R5: The force operation (`start_force`) first reads RX status again and again while bit 0 (half rate) of the returned word is 1. It stops after at most POLL_MAX reads and then continues whether or not the bit cleared.
- R6: The force operation then reads RX status (value V) and writes RX override five times, each write building on the previous one:
  - V with bit 14 = 0;
  - then bit 14 = 1;
  - then bits 10:8 = 3'b011;
  - then bit 11 = 1;
  - then bit 11 = 0.
- R7: After the last RX override write completes, exactly SETTLE_CYC cycles pass with no command and no `done`.
- R8: If bit 3 of the captured attenuation is 1, the force operation ends after the settle time with no transmit command.
- R9: Otherwise the force operation reads TX status (value T) and writes TX override three times, each write building on the previous one:
  - T with bit 15 = 0;
  - then bit 15 = 1;
  - then attenuation bits 2:0 ORed into bits 12:10.
- R10: `done` is a one-cycle pulse in the cycle after the final step. `busy` is high from the cycle after a start until and including the `done` cycle, and low after it.
- R11: Start requests while `busy` is high have no effect. If both start inputs are high in the same idle cycle, the clear operation runs. Lane and attenuation are captured at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_clear | input | 1 | Start the clear operation |
| start_force | input | 1 | Start the force operation |
| lane_sel | input | LANE_W | Lane to operate on, captured at start |
| tx_atten | input | ATTEN_W | Attenuation; MSB set means skip TX step |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| cmd_valid | output | 1 | Register command presented |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Register address |
| cmd_wdata | output | DATA_W | Write data |
| cmd_done | input | 1 | Access engine finished current command |
| cmd_rdata | input | DATA_W | Read data, valid with `cmd_done` on reads |

## Verification
The bench builds the block with POLL_MAX = 4 and SETTLE_CYC = 12. With these values the half-rate poll can be driven all the way to its read limit, and an exact count of the quiet settle window stays inside a short run. The default values (1000 reads, a multi-millisecond settle) leave the control flow unchanged but would make these two corners too long to reach. The bench varies the access engine latency from zero to two wait cycles, so command holding is exercised on both immediate and delayed completions across all four lanes.

// File: rtl/lane_ovr_pkg.sv
package lane_ovr_pkg;

  localparam logic [15:0] RX_STS_BASE = 16'h2002;
  localparam logic [15:0] TX_STS_BASE = 16'h2001;
  localparam logic [15:0] RX_OVR_BASE = 16'h2005;
  localparam logic [15:0] TX_OVR_BASE = 16'h2004;
  localparam int LANE_SHIFT    = 8;
  localparam int HALF_RATE_BIT = 0;
  localparam int DPLL_LSB      = 8;
  localparam int DPLL_W        = 3;
  localparam int DPLL_RST_BIT  = 11;
  localparam int ATTEN_LSB     = 10;
  localparam int RX_OVR_EN_BIT = 14;
  localparam int TX_OVR_EN_BIT = 15;

  typedef enum logic [1:0] {
    REG_RX_STS,
    REG_TX_STS,
    REG_RX_OVR,
    REG_TX_OVR
  } lane_reg_e;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_CLR_RD,
    ST_CLR_WR,
    ST_POLL,
    ST_RX_RD,
    ST_RX_W0,
    ST_RX_W1,
    ST_RX_W2,
    ST_RX_W3,
    ST_RX_W4,
    ST_SETTLE,
    ST_TX_RD,
    ST_TX_W0,
    ST_TX_W1,
    ST_TX_W2,
    ST_FIN
  } seq_state_e;

  function automatic logic st_is_read(seq_state_e s);
    return s inside {ST_CLR_RD, ST_POLL, ST_RX_RD, ST_TX_RD};
  endfunction

  function automatic logic st_is_write(seq_state_e s);
    return s inside {ST_CLR_WR, ST_RX_W0, ST_RX_W1, ST_RX_W2, ST_RX_W3,
                     ST_RX_W4, ST_TX_W0, ST_TX_W1, ST_TX_W2};
  endfunction

  function automatic logic st_is_tx(seq_state_e s);
    return s inside {ST_TX_RD, ST_TX_W0, ST_TX_W1, ST_TX_W2};
  endfunction

endpackage

// File: rtl/lane_ovr_rst_sync.sv
module lane_ovr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lane_ovr_addr.sv
module lane_ovr_addr
  import lane_ovr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LANE_W = 2
) (
  input  lane_reg_e          reg_sel,
  input  logic [LANE_W-1:0]  lane,
  output logic [ADDR_W-1:0]  addr
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] lane_off;

  always_comb begin
    case (reg_sel)
      REG_RX_STS: base = ADDR_W'(RX_STS_BASE);
      REG_TX_STS: base = ADDR_W'(TX_STS_BASE);
      REG_RX_OVR: base = ADDR_W'(RX_OVR_BASE);
      default:    base = ADDR_W'(TX_OVR_BASE);
    endcase
  end

  assign lane_off = ADDR_W'(lane) << LANE_SHIFT;
  assign addr     = base + lane_off;
endmodule

// File: rtl/lane_ovr_word.sv
module lane_ovr_word
  import lane_ovr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ATTEN_FLD_W = 3,
  parameter int DPLL_MODE   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  seq_state_e             state,
  input  logic                   cmd_done,
  input  logic [DATA_W-1:0]      cmd_rdata,
  input  logic [ATTEN_FLD_W-1:0] atten_fld,
  output logic [DATA_W-1:0]      wdata
);
  logic [DATA_W-1:0] shadow_q;
  logic [DATA_W-1:0] shadow_d;
  logic              shadow_en;
  logic              is_wr;
  logic              is_rd;

  assign is_wr = st_is_write(state);
  assign is_rd = st_is_read(state);

  always_comb begin
    wdata = shadow_q;
    case (state)
      ST_CLR_WR, ST_RX_W0: wdata[RX_OVR_EN_BIT] = 1'b0;
      ST_RX_W1:            wdata[RX_OVR_EN_BIT] = 1'b1;
      ST_RX_W2:            wdata[DPLL_LSB +: DPLL_W] = DPLL_W'(DPLL_MODE);
      ST_RX_W3:            wdata[DPLL_RST_BIT] = 1'b1;
      ST_RX_W4:            wdata[DPLL_RST_BIT] = 1'b0;
      ST_TX_W0:            wdata[TX_OVR_EN_BIT] = 1'b0;
      ST_TX_W1:            wdata[TX_OVR_EN_BIT] = 1'b1;
      ST_TX_W2:            wdata[ATTEN_LSB +: ATTEN_FLD_W] =
                             shadow_q[ATTEN_LSB +: ATTEN_FLD_W] | atten_fld;
      default: ;
    endcase
  end

  assign shadow_en = cmd_done && (is_wr || is_rd);
  assign shadow_d  = is_wr ? wdata : cmd_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shadow_q <= '0;
    else if (shadow_en) shadow_q <= shadow_d;
  end

  // R6
  rx_en_before_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX_W2) |-> shadow_q[RX_OVR_EN_BIT]);
  // R6
  dpll_rst_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RX_W4) |-> shadow_q[DPLL_RST_BIT]);
  // R9
  tx_en_before_atten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX_W2) |-> shadow_q[TX_OVR_EN_BIT]);
endmodule

// File: rtl/lane_ovr_ctrl.sv
module lane_ovr_ctrl
  import lane_ovr_pkg::*;
#(
  parameter int LANE_W     = 2,
  parameter int ATTEN_W    = 4,
  parameter int POLL_MAX   = 1000,
  parameter int SETTLE_CYC = 1500000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_clear,
  input  logic               start_force,
  input  logic [LANE_W-1:0]  lane_in,
  input  logic [ATTEN_W-1:0] atten_in,
  input  logic               cmd_done,
  input  logic               half_rate,
  output seq_state_e         state,
  output logic [LANE_W-1:0]  lane_q,
  output logic [ATTEN_W-1:0] atten_q,
  output lane_reg_e          reg_sel,
  output logic               cmd_valid,
  output logic               cmd_write,
  output logic               busy,
  output logic               done
);
  localparam int PCW = $clog2(POLL_MAX + 1);
  localparam int SCW = $clog2(SETTLE_CYC + 1);
  localparam logic [PCW-1:0] POLL_LAST  = PCW'(POLL_MAX - 1);
  localparam logic [SCW-1:0] SETTLE_TOP = SCW'(SETTLE_CYC - 1);

  seq_state_e      state_q, state_d;
  logic [PCW-1:0]  poll_q, poll_d;
  logic [SCW-1:0]  settle_q, settle_d;
  logic            cap_en;
  logic            skip_tx;

  assign cap_en  = (state_q == ST_IDLE) && (start_clear || start_force);
  assign skip_tx = atten_q[ATTEN_W-1];

  always_comb begin
    state_d  = state_q;
    poll_d   = poll_q;
    settle_d = settle_q;
    case (state_q)
      ST_IDLE: begin
        if (start_clear) begin
          state_d = ST_CLR_RD;
        end else if (start_force) begin
          state_d = ST_POLL;
          poll_d  = '0;
        end
      end
      ST_CLR_RD: if (cmd_done) state_d = ST_CLR_WR;
      ST_CLR_WR: if (cmd_done) state_d = ST_FIN;
      ST_POLL: begin
        if (cmd_done) begin
          if (half_rate && (poll_q != POLL_LAST)) poll_d = poll_q + 1'b1;
          else                                    state_d = ST_RX_RD;
        end
      end
      ST_RX_RD: if (cmd_done) state_d = ST_RX_W0;
      ST_RX_W0: if (cmd_done) state_d = ST_RX_W1;
      ST_RX_W1: if (cmd_done) state_d = ST_RX_W2;
      ST_RX_W2: if (cmd_done) state_d = ST_RX_W3;
      ST_RX_W3: if (cmd_done) state_d = ST_RX_W4;
      ST_RX_W4: begin
        if (cmd_done) begin
          state_d  = ST_SETTLE;
          settle_d = SETTLE_TOP;
        end
      end
      ST_SETTLE: begin
        if (settle_q == '0) state_d = skip_tx ? ST_FIN : ST_TX_RD;
        else                settle_d = settle_q - 1'b1;
      end
      ST_TX_RD: if (cmd_done) state_d = ST_TX_W0;
      ST_TX_W0: if (cmd_done) state_d = ST_TX_W1;
      ST_TX_W1: if (cmd_done) state_d = ST_TX_W2;
      ST_TX_W2: if (cmd_done) state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      poll_q   <= '0;
      settle_q <= '0;
    end else begin
      state_q  <= state_d;
      poll_q   <= poll_d;
      settle_q <= settle_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q  <= '0;
      atten_q <= '0;
    end else if (cap_en) begin
      lane_q  <= lane_in;
      atten_q <= atten_in;
    end
  end

  always_comb begin
    cmd_valid = st_is_read(state_q) || st_is_write(state_q);
    cmd_write = st_is_write(state_q);
    case (state_q)
      ST_CLR_WR, ST_RX_W0, ST_RX_W1, ST_RX_W2, ST_RX_W3, ST_RX_W4:
        reg_sel = REG_RX_OVR;
      ST_TX_RD:
        reg_sel = REG_TX_STS;
      ST_TX_W0, ST_TX_W1, ST_TX_W2:
        reg_sel = REG_TX_OVR;
      default:
        reg_sel = REG_RX_STS;
    endcase
  end

  assign state = state_q;
  assign busy  = (state_q != ST_IDLE);
  assign done  = (state_q == ST_FIN);

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> (poll_q < PCW'(POLL_MAX)));
  // R8
  skip_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_is_tx(state_q) |-> !atten_q[ATTEN_W-1]);
  // R11
  capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(lane_q) && $stable(atten_q)));
endmodule

// File: rtl/lane_ovr_seq.sv
module lane_ovr_seq
  import lane_ovr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int LANE_W     = 2,
  parameter int ATTEN_W    = 4,
  parameter int DPLL_MODE  = 3,
  parameter int POLL_MAX   = 1000,
  parameter int SETTLE_CYC = 1500000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_clear,
  input  logic               start_force,
  input  logic [LANE_W-1:0]  lane_sel,
  input  logic [ATTEN_W-1:0] tx_atten,
  output logic               busy,
  output logic               done,
  output logic               cmd_valid,
  output logic               cmd_write,
  output logic [ADDR_W-1:0]  cmd_addr,
  output logic [DATA_W-1:0]  cmd_wdata,
  input  logic               cmd_done,
  input  logic [DATA_W-1:0]  cmd_rdata
);
  localparam int ATTEN_FLD_W = ATTEN_W - 1;

  logic               rst_n_int;
  seq_state_e         state;
  logic [LANE_W-1:0]  lane_q;
  logic [ATTEN_W-1:0] atten_q;
  lane_reg_e          reg_sel;

  lane_ovr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lane_ovr_ctrl #(
    .LANE_W     (LANE_W),
    .ATTEN_W    (ATTEN_W),
    .POLL_MAX   (POLL_MAX),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .start_clear (start_clear),
    .start_force (start_force),
    .lane_in     (lane_sel),
    .atten_in    (tx_atten),
    .cmd_done    (cmd_done),
    .half_rate   (cmd_rdata[HALF_RATE_BIT]),
    .state       (state),
    .lane_q      (lane_q),
    .atten_q     (atten_q),
    .reg_sel     (reg_sel),
    .cmd_valid   (cmd_valid),
    .cmd_write   (cmd_write),
    .busy        (busy),
    .done        (done)
  );

  lane_ovr_addr #(
    .ADDR_W (ADDR_W),
    .LANE_W (LANE_W)
  ) u_addr (
    .reg_sel (reg_sel),
    .lane    (lane_q),
    .addr    (cmd_addr)
  );

  lane_ovr_word #(
    .DATA_W      (DATA_W),
    .ATTEN_FLD_W (ATTEN_FLD_W),
    .DPLL_MODE   (DPLL_MODE)
  ) u_word (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .state     (state),
    .cmd_done  (cmd_done),
    .cmd_rdata (cmd_rdata),
    .atten_fld (atten_q[ATTEN_FLD_W-1:0]),
    .wdata     (cmd_wdata)
  );

  // R4
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_valid && !cmd_done) |=>
      (cmd_valid && $stable(cmd_write) && $stable(cmd_addr) && $stable(cmd_wdata)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |=> !done);
  // R10
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |=> !busy);
  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |-> (busy && !cmd_valid));
endmodule

// File: tb/lane_ovr_seq_tb.sv
module lane_ovr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int POLL_MAX   = 4;
  localparam int SETTLE_CYC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_clear = 1'b0;
  logic        start_force = 1'b0;
  logic [1:0]  lane_sel = 2'd0;
  logic [3:0]  tx_atten = 4'd0;
  logic        busy, done, cmd_valid, cmd_write;
  logic [15:0] cmd_addr, cmd_wdata;
  logic        cmd_done = 1'b0;
  logic [15:0] cmd_rdata = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_ovr_seq #(
    .POLL_MAX   (POLL_MAX),
    .SETTLE_CYC (SETTLE_CYC)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .start_clear (start_clear), .start_force (start_force),
    .lane_sel (lane_sel), .tx_atten (tx_atten),
    .busy (busy), .done (done),
    .cmd_valid (cmd_valid), .cmd_write (cmd_write),
    .cmd_addr (cmd_addr), .cmd_wdata (cmd_wdata),
    .cmd_done (cmd_done), .cmd_rdata (cmd_rdata)
  );

  // expected command list (written by the stimulus process only)
  logic        exp_w   [0:255];
  logic [15:0] exp_a   [0:255];
  logic [15:0] exp_d   [0:255];
  logic [15:0] exp_r   [0:255];
  int          exp_gap [0:255];
  string       exp_tag [0:255];
  string       op_tag  [0:31];
  int          wr_idx = 0;
  int          ops_started = 0;
  int          t_checks = 0, t_fails = 0;
  bit          finished = 1'b0;

  // model-side state (written by the monitor only)
  int rd_idx = 0;
  int ops_finished = 0;
  int idle_left = 0;
  int wait_cnt = 0;
  int m_checks = 0, m_fails = 0;

  task automatic mchk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic tchk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // Reference model: walks the expected command list one cycle at a time,
  // plays the access engine, and compares every output on every clock.
  always @(negedge clk) begin
    if (rst_n) begin
      bit active;
      int lat;
      if (cmd_done) cmd_done = 1'b0;
      active = (ops_started != ops_finished);
      if (idle_left > 0) begin
        mchk(!cmd_valid && !done, "R7", "quiet settle window valid|done",
             {cmd_valid, done}, 0);
        mchk(busy, "R10", "busy during settle", busy, 1);
        idle_left--;
      end else if (active && (rd_idx == wr_idx)) begin
        mchk(done && !cmd_valid, op_tag[ops_finished], "end pulse done/valid",
             {done, cmd_valid}, 2'b10);
        mchk(busy, "R10", "busy in done cycle", busy, 1);
        ops_finished++;
      end else if (active) begin
        string tg;
        tg = (wait_cnt > 0) ? "R4" : exp_tag[rd_idx];
        mchk(cmd_valid && busy && !done, tg, "command presented valid/busy/done",
             {cmd_valid, busy, done}, 3'b110);
        mchk(cmd_write == exp_w[rd_idx], tg, "command direction", cmd_write, exp_w[rd_idx]);
        mchk(cmd_addr == exp_a[rd_idx], (wait_cnt > 0) ? "R4" : "R2", "command address",
             cmd_addr, exp_a[rd_idx]);
        if (exp_w[rd_idx])
          mchk(cmd_wdata == exp_d[rd_idx], tg, "write data", cmd_wdata, exp_d[rd_idx]);
        lat = rd_idx % 3;
        if (wait_cnt >= lat) begin
          cmd_done  = 1'b1;
          cmd_rdata = exp_w[rd_idx] ? 16'hDEAD : exp_r[rd_idx];
          idle_left = exp_gap[rd_idx];
          rd_idx++;
          wait_cnt = 0;
        end else begin
          wait_cnt++;
        end
      end else begin
        mchk(!cmd_valid && !done && !busy, "R11", "idle outputs valid/done/busy",
             {cmd_valid, done, busy}, 0);
      end
    end
  end

  task automatic push(input bit w, input logic [15:0] a, input logic [15:0] d,
                      input logic [15:0] r, input int gap, input string tag);
    exp_w[wr_idx] = w; exp_a[wr_idx] = a; exp_d[wr_idx] = d;
    exp_r[wr_idx] = r; exp_gap[wr_idx] = gap; exp_tag[wr_idx] = tag;
    wr_idx++;
  endtask

  task automatic plan_clear(input logic [1:0] ln, input logic [15:0] rx, input string tag);
    logic [15:0] off;
    off = 16'(ln) * 16'h0100;
    push(1'b0, 16'h2002 + off, 16'h0, rx, 0, tag);
    push(1'b1, 16'h2005 + off, rx & ~16'h4000, 16'h0, 0, tag);
  endtask

  task automatic plan_force(input logic [1:0] ln, input logic [3:0] at, input int hr_n,
                            input logic [15:0] rx, input logic [15:0] tx);
    logic [15:0] off, v;
    int n;
    off = 16'(ln) * 16'h0100;
    n = (hr_n < POLL_MAX) ? hr_n + 1 : POLL_MAX;
    for (int i = 0; i < n; i++)
      push(1'b0, 16'h2002 + off, 16'h0, (i < hr_n) ? 16'h0001 : 16'h0000, 0, "R5");
    push(1'b0, 16'h2002 + off, 16'h0, rx, 0, "R6");
    v = rx & ~16'h4000;                push(1'b1, 16'h2005 + off, v, 16'h0, 0, "R6");
    v = v | 16'h4000;                  push(1'b1, 16'h2005 + off, v, 16'h0, 0, "R6");
    v = (v & ~16'h0700) | 16'h0300;    push(1'b1, 16'h2005 + off, v, 16'h0, 0, "R6");
    v = v | 16'h0800;                  push(1'b1, 16'h2005 + off, v, 16'h0, 0, "R6");
    v = v & ~16'h0800;                 push(1'b1, 16'h2005 + off, v, 16'h0, SETTLE_CYC, "R6");
    if (!at[3]) begin
      push(1'b0, 16'h2001 + off, 16'h0, tx, 0, "R9");
      v = tx & ~16'h8000;              push(1'b1, 16'h2004 + off, v, 16'h0, 0, "R9");
      v = v | 16'h8000;                push(1'b1, 16'h2004 + off, v, 16'h0, 0, "R9");
      v = v | (16'(at[2:0]) << 10);    push(1'b1, 16'h2004 + off, v, 16'h0, 0, "R9");
    end
  endtask

  task automatic launch(input bit c, input bit f, input logic [1:0] ln,
                        input logic [3:0] at, input string tag);
    op_tag[ops_started] = tag;
    @(posedge clk); #2;
    start_clear = c; start_force = f; lane_sel = ln; tx_atten = at;
    @(posedge clk); #2;
    start_clear = 1'b0; start_force = 1'b0;
    ops_started++;
  endtask

  task automatic poke_starts();
    @(posedge clk); #2;
    start_clear = 1'b1; start_force = 1'b1; lane_sel = 2'd0; tx_atten = 4'h8;
    @(posedge clk); #2;
    start_clear = 1'b0; start_force = 1'b0;
  endtask

  task automatic finish_op(input string tag);
    while (ops_finished != ops_started) @(posedge clk);
    repeat (3) @(posedge clk);
    tchk(rd_idx == wr_idx, tag, "all expected commands consumed", rd_idx, wr_idx);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    tchk(!busy && !done && !cmd_valid, "R1", "outputs in reset",
         {busy, done, cmd_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #2;
    tchk(!busy && !done && !cmd_valid, "R1", "outputs after reset release",
         {busy, done, cmd_valid}, 0);

    // R3: clear, lane 0
    plan_clear(2'd0, 16'hFFFF, "R3");
    launch(1'b1, 1'b0, 2'd0, 4'd0, "R10");
    finish_op("R3");

    // R2 and R3: clear on lane 3 moves addresses by 0x300
    plan_clear(2'd3, 16'h4321, "R3");
    launch(1'b1, 1'b0, 2'd3, 4'd0, "R10");
    finish_op("R2");

    // R6, R7, R9: force, no half-rate
    plan_force(2'd1, 4'd5, 0, 16'h5A5A, 16'h1234);
    launch(1'b0, 1'b1, 2'd1, 4'd5, "R10");
    finish_op("R9");

    // R5: half-rate clears after two reads
    plan_force(2'd2, 4'd2, 2, 16'hC7FF, 16'hFFFF);
    launch(1'b0, 1'b1, 2'd2, 4'd2, "R10");
    finish_op("R5");

    // R5: half-rate never clears, poll gives up at the limit
    plan_force(2'd0, 4'd7, 10, 16'h0000, 16'h0000);
    launch(1'b0, 1'b1, 2'd0, 4'd7, "R10");
    finish_op("R5");

    // R8: attenuation bit 3 skips the transmit step
    plan_force(2'd3, 4'hC, 1, 16'h0F00, 16'hAAAA);
    launch(1'b0, 1'b1, 2'd3, 4'hC, "R8");
    finish_op("R8");

    // R11: start requests during an operation are ignored
    plan_force(2'd1, 4'd1, 1, 16'h3C3C, 16'h7E00);
    launch(1'b0, 1'b1, 2'd1, 4'd1, "R11");
    repeat (4) @(posedge clk);
    poke_starts();
    repeat (9) @(posedge clk);
    poke_starts();
    finish_op("R11");

    // R11: both starts together pick the clear operation
    plan_clear(2'd2, 16'h4000, "R11");
    launch(1'b1, 1'b1, 2'd2, 4'd3, "R11");
    finish_op("R11");

    repeat (5) @(posedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             t_checks + m_checks, t_fails + m_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures",
               t_checks + m_checks + 1, t_fails + m_fails + 1);
      $finish;
    end
  end
endmodule